// File: doc/BRIEF.md
# DMA Channel Address Generator

This block produces the bus address stream for one side (read side or write side) of a DMA channel. Software loads a 32-bit current-address register while the channel is disabled. Each transfer is started by a pulse. The block then presents one or more bus beats, each with an address and a beat size. On the last beat of the transfer it computes the address for the next transfer and loads it into the register.

The next address depends on a 2-bit update mode and a 2-bit transfer size. The address can stay fixed, move by a 32-bit offset, step up or step down. A word or longword that does not sit on its natural boundary is issued as several narrower aligned beats. The register can also be restored to its programmed value when an external block counter signals the end of a block. Separately, the low address bits can be confined to a power-of-two window so that they wrap while the upper bits stay fixed.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, `sw_rdata_o` is 0 and both `beat_valid_o` and `done_o` are 0.
- R2: A `sw_we_i` pulse loads `sw_wdata_i` into the address register and into the restore register. It takes effect only when `chan_en_i` is 0 and no transfer is in progress. A write made while `chan_en_i` is 1 leaves `sw_rdata_o` unchanged.
- R3: When a transfer completes, the register holds the transfer's start address S updated by `mode_i`:
  - 00: S (fixed)
  - 01: S plus the offset
  - 10: S+N
  - 11: S-N

  N is the transfer size in bytes: 1 for `size_i`=00, 2 for 01, and 4 for 10 or 11.
- R4: In mode 01, `offset_i` is added modulo 2^32, whatever the transfer size.
- R5: While a beat is presented and `ack_i` is low, `addr_o` and `sw_rdata_o` hold their values. The register is reloaded only at the acknowledge of the last beat.
- R6: Beats are aligned to their size. `beat_size_o` is 00 for a byte, 01 for a word and 10 for a longword. The beats of a transfer at start address S are:
  - aligned transfer: one beat
  - word at odd S: two byte beats
  - longword at S mod 4 = 2: two word beats
  - longword at odd S: byte, word, byte

  Beats are issued at the lowest address that is still free.
- R7: In mode 11 the same beats are issued in descending address order. In every other mode they are issued in ascending order.
- R8: `done_o` is high for exactly one cycle, in the cycle after the last beat is acknowledged. In that same cycle `sw_rdata_o` already shows the new address.
- R9: If `rpt_en_i` and `blk_end_i` are both 1 when the last beat is acknowledged, the register returns to the last value written by software. If `rpt_en_i` is 0, `blk_end_i` has no effect.
- R10: With `ext_en_i` set, the window is 2^k bytes, where k is `ext_sz_i` clamped to the range 1..23. Address bits at and above position k keep the transfer's start value, and the bits below k wrap. This applies both when stepping up and when stepping down.
- R11: `start_i` is ignored while a transfer is in progress. `ack_i` is ignored while no beat is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_en_i | input | 1 | Channel enabled; blocks software writes |
| sw_we_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Whole address register, read as one value |
| mode_i | input | 2 | Update mode: fixed, offset, up, down |
| size_i | input | 2 | Transfer size: byte, word, longword |
| offset_i | input | 32 | Offset added in mode 01 |
| rpt_en_i | input | 1 | Enables restore at block end |
| blk_end_i | input | 1 | Block end from the external transfer counter |
| ext_en_i | input | 1 | Enables the low-bit wrap window |
| ext_sz_i | input | 5 | Window size exponent |
| start_i | input | 1 | Starts one transfer |
| ack_i | input | 1 | Current beat accepted by the bus |
| beat_valid_o | output | 1 | A beat is being presented |
| addr_o | output | 32 | Beat address |
| beat_size_o | output | 2 | Beat size code |
| done_o | output | 1 | Transfer complete, one-cycle pulse |

## Verification
- **Start to first beat.** The first beat appears one cycle after the edge that samples `start_i`.
- **Beat to beat.** Each following beat appears one cycle after the edge that samples `ack_i` high.
- **Completion.** `done_o` and the new register value appear together, one cycle after the last acknowledge.

The bench drives its inputs just after the rising edge. A monitor compares every acknowledged beat against the queue at the falling edge, that is, before the edge that consumes the beat. Completion is checked just after the edge that follows the last acknowledge. The absence of `done_o` is checked one cycle later. Stalled acknowledges hold a beat for several cycles, so the queue also catches any beat that advances early or is repeated.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [1:0] {
    UPD_FIX = 2'b00,
    UPD_OFS = 2'b01,
    UPD_INC = 2'b10,
    UPD_DEC = 2'b11
  } upd_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] bytes_code(input logic [2:0] nb);
    case (nb)
      3'd1:    return 2'b00;
      3'd2:    return 2'b01;
      default: return 2'b10;
    endcase
  endfunction
endpackage

// File: rtl/dag_piece.sv
// Picks the next aligned beat from a byte pointer and the bytes still to move.
// Going down, ptr_i is the exclusive upper end of the unsent range.
module dag_piece #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [2:0]    rem_i,
  input  logic          down_i,
  output logic [AW-1:0] addr_o,
  output logic [2:0]    nbytes_o
);
  always_comb begin
    if (rem_i >= 3'd4 && ptr_i[1:0] == 2'b00)  nbytes_o = 3'd4;
    else if (rem_i >= 3'd2 && !ptr_i[0])       nbytes_o = 3'd2;
    else                                       nbytes_o = 3'd1;
    addr_o = down_i ? ptr_i - AW'(nbytes_o) : ptr_i;
  end
endmodule

// File: rtl/dag_next.sv
// Computes the post-transfer address: mode step, window wrap, block restore.
module dag_next
  import dag_pkg::*;
#(
  parameter int AW      = 32,
  parameter int EXTW    = 5,
  parameter int EXT_MAX = 23
) (
  input  logic [AW-1:0]   xs_i,
  input  logic [AW-1:0]   offset_i,
  input  logic [AW-1:0]   restore_addr_i,
  input  upd_e            mode_i,
  input  logic [2:0]      nbytes_i,
  input  logic            ext_en_i,
  input  logic [EXTW-1:0] ext_sz_i,
  input  logic            restore_i,
  output logic [AW-1:0]   nxt_o,
  output logic [AW-1:0]   mask_o
);
  logic [EXTW-1:0] k;
  logic [AW-1:0]   raw;

  always_comb begin
    if (ext_sz_i == '0)                    k = EXTW'(1);
    else if (ext_sz_i > EXTW'(EXT_MAX))    k = EXTW'(EXT_MAX);
    else                                   k = ext_sz_i;
  end

  for (genvar i = 0; i < AW; i++) begin : g_mask
    assign mask_o[i] = (int'(k) > i);
  end

  always_comb begin
    case (mode_i)
      UPD_OFS: raw = xs_i + offset_i;
      UPD_INC: raw = xs_i + AW'(nbytes_i);
      UPD_DEC: raw = xs_i - AW'(nbytes_i);
      default: raw = xs_i;
    endcase
    if (restore_i)     nxt_o = restore_addr_i;
    else if (ext_en_i) nxt_o = (xs_i & ~mask_o) | (raw & mask_o);
    else               nxt_o = raw;
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dag_pkg::*;
#(
  parameter int AW      = 32,
  parameter int EXTW    = 5,
  parameter int EXT_MAX = 23
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            chan_en_i,
  input  logic            sw_we_i,
  input  logic [AW-1:0]   sw_wdata_i,
  output logic [AW-1:0]   sw_rdata_o,
  input  logic [1:0]      mode_i,
  input  logic [1:0]      size_i,
  input  logic [AW-1:0]   offset_i,
  input  logic            rpt_en_i,
  input  logic            blk_end_i,
  input  logic            ext_en_i,
  input  logic [EXTW-1:0] ext_sz_i,
  input  logic            start_i,
  input  logic            ack_i,
  output logic            beat_valid_o,
  output logic [AW-1:0]   addr_o,
  output logic [1:0]      beat_size_o,
  output logic            done_o
);
  logic          busy_q, down_q, done_q;
  logic [AW-1:0] cur_q, base_q, xs_q, ptr_q;
  logic [2:0]    rem_q, nb_q, pc_bytes, req_bytes;
  upd_e          mode_q, req_mode;
  logic [AW-1:0] pc_addr, nxt, ext_mask;
  logic          start_go, beat, last;

  assign req_bytes = size_bytes(size_i);
  assign req_mode  = upd_e'(mode_i);
  assign start_go  = start_i && !busy_q;
  assign beat      = busy_q && ack_i;
  assign last      = beat && (rem_q == pc_bytes);

  dag_piece #(.AW(AW)) u_piece (
    .ptr_i    (ptr_q),
    .rem_i    (rem_q),
    .down_i   (down_q),
    .addr_o   (pc_addr),
    .nbytes_o (pc_bytes)
  );

  dag_next #(.AW(AW), .EXTW(EXTW), .EXT_MAX(EXT_MAX)) u_next (
    .xs_i           (xs_q),
    .offset_i       (offset_i),
    .restore_addr_i (base_q),
    .mode_i         (mode_q),
    .nbytes_i       (nb_q),
    .ext_en_i       (ext_en_i),
    .ext_sz_i       (ext_sz_i),
    .restore_i      (rpt_en_i && blk_end_i),
    .nxt_o          (nxt),
    .mask_o         (ext_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      down_q <= 1'b0;
      done_q <= 1'b0;
      cur_q  <= '0;
      base_q <= '0;
      xs_q   <= '0;
      ptr_q  <= '0;
      rem_q  <= '0;
      nb_q   <= '0;
      mode_q <= UPD_FIX;
    end else begin
      done_q <= last;
      if (start_go) begin
        busy_q <= 1'b1;
        xs_q   <= cur_q;
        mode_q <= req_mode;
        nb_q   <= req_bytes;
        rem_q  <= req_bytes;
        down_q <= (req_mode == UPD_DEC);
        // going down, the pointer starts at the exclusive top of the transfer
        ptr_q  <= (req_mode == UPD_DEC) ? cur_q + AW'(req_bytes) : cur_q;
      end else if (beat) begin
        ptr_q <= down_q ? ptr_q - AW'(pc_bytes) : ptr_q + AW'(pc_bytes);
        rem_q <= rem_q - pc_bytes;
        if (last) begin
          busy_q <= 1'b0;
          cur_q  <= nxt;
        end
      end else if (sw_we_i && !chan_en_i && !busy_q) begin
        cur_q  <= sw_wdata_i;
        base_q <= sw_wdata_i;
      end
    end
  end

  assign sw_rdata_o   = cur_q;
  assign beat_valid_o = busy_q;
  assign addr_o       = pc_addr;
  assign beat_size_o  = bytes_code(pc_bytes);
  assign done_o       = done_q;

  p_wr_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && chan_en_i && !busy_q) |=> $stable(cur_q));

  p_hold_on_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ack_i) |=> ($stable(cur_q) && $stable(addr_o)));

  p_beat_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (beat_size_o != 2'b11));

  p_beat_aligned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> ((beat_size_o == 2'b00) ||
                (beat_size_o == 2'b01 && !addr_o[0]) ||
                (beat_size_o == 2'b10 && addr_o[1:0] == 2'b00)));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_upper_fixed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && ext_en_i && !(rpt_en_i && blk_end_i)) |=>
      (((cur_q ^ $past(xs_q)) & ~$past(ext_mask)) == '0));

  p_idle_ack_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && ack_i && !sw_we_i) |=> $stable(cur_q));
endmodule

// File: tb/dma_addr_gen_tb.sv
module dma_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en_i = 1'b0, sw_we_i = 1'b0;
  logic [31:0] sw_wdata_i = '0, offset_i = '0;
  logic [31:0] sw_rdata_o, addr_o;
  logic [1:0]  mode_i = '0, size_i = '0, beat_size_o;
  logic        rpt_en_i = 1'b0, blk_end_i = 1'b0, ext_en_i = 1'b0;
  logic [4:0]  ext_sz_i = '0;
  logic        start_i = 1'b0, ack_i = 1'b0;
  logic        beat_valid_o, done_o;

  int          nvec = 0, nerr = 0;
  logic [33:0] exp_q[$];
  logic [31:0] model_cur = '0, model_base = '0;

  always #10 clk = ~clk;

  dma_addr_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .chan_en_i(chan_en_i), .sw_we_i(sw_we_i),
    .sw_wdata_i(sw_wdata_i), .sw_rdata_o(sw_rdata_o), .mode_i(mode_i),
    .size_i(size_i), .offset_i(offset_i), .rpt_en_i(rpt_en_i),
    .blk_end_i(blk_end_i), .ext_en_i(ext_en_i), .ext_sz_i(ext_sz_i),
    .start_i(start_i), .ack_i(ack_i), .beat_valid_o(beat_valid_o),
    .addr_o(addr_o), .beat_size_o(beat_size_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [33:0] act, input logic [33:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
  endtask

  // monitor: compare each acknowledged beat against the scoreboard
  always @(negedge clk) begin
    if (rst_n && beat_valid_o && ack_i) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 extra beat", {beat_size_o, addr_o}, '0);
      else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        chk({beat_size_o, addr_o} == e, "R6/R7 beat", {beat_size_o, addr_o}, e);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic sw_write(input logic [31:0] v, input logic en);
    chan_en_i = en; sw_we_i = 1'b1; sw_wdata_i = v;
    step();
    sw_we_i = 1'b0; chan_en_i = 1'b0;
    if (!en) begin model_cur = v; model_base = v; end
    chk(sw_rdata_o == model_cur, "R2 sw write", {2'b0, sw_rdata_o}, {2'b0, model_cur});
  endtask

  function automatic logic [31:0] win_mask(input logic [4:0] sz);
    int k;
    k = (sz == 0) ? 1 : (sz > 23) ? 23 : int'(sz);
    return (32'd1 << k) - 32'd1;
  endfunction

  task automatic push_beats(input logic [31:0] s, input int n, input bit down);
    logic [33:0] p[3];
    int c;
    c = 0;
    if (n == 1) begin p[0] = {2'b00, s}; c = 1; end
    else if (n == 2) begin
      if (!s[0]) begin p[0] = {2'b01, s}; c = 1; end
      else begin p[0] = {2'b00, s}; p[1] = {2'b00, s + 32'd1}; c = 2; end
    end else begin
      if (s[1:0] == 2'b00) begin p[0] = {2'b10, s}; c = 1; end
      else if (s[1:0] == 2'b10) begin p[0] = {2'b01, s}; p[1] = {2'b01, s + 32'd2}; c = 2; end
      else begin p[0] = {2'b00, s}; p[1] = {2'b01, s + 32'd1}; p[2] = {2'b00, s + 32'd3}; c = 3; end
    end
    for (int i = 0; i < c; i++) exp_q.push_back(down ? p[c-1-i] : p[i]);
  endtask

  // one transfer: R3 R4 R5 R8 R9 R10 R11 depending on settings
  task automatic xfer(input logic [1:0] md, input logic [1:0] sz, input bit blk,
                      input bit stall, input bit dup, input string req);
    logic [31:0] s, raw, e;
    int n, k;
    s = model_cur;
    n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    case (md)
      2'b00: raw = s;
      2'b01: raw = s + offset_i;
      2'b10: raw = s + n;
      default: raw = s - n;
    endcase
    e = raw;
    if (ext_en_i) e = (s & ~win_mask(ext_sz_i)) | (raw & win_mask(ext_sz_i));
    if (rpt_en_i && blk) e = model_base;
    push_beats(s, n, md == 2'b11);
    mode_i = md; size_i = sz; blk_end_i = blk;
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    k = 0;
    while (k < 40) begin
      ack_i = stall ? k[0] : 1'b1;
      start_i = (dup && k == 0);
      step();
      if (done_o) break;
      k++;
    end
    ack_i = 1'b0; start_i = 1'b0; blk_end_i = 1'b0;
    chk(done_o == 1'b1, "R8 done pulse", {33'b0, done_o}, 34'd1);
    chk(sw_rdata_o == e, req, {2'b0, sw_rdata_o}, {2'b0, e});
    chk(exp_q.size() == 0, "R6 beat count", 34'(exp_q.size()), 34'd0);
    exp_q.delete();
    model_cur = e;
    step();
    chk(done_o == 1'b0, "R8 done one cycle", {33'b0, done_o}, 34'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R8 watchdog", 34'd0, 34'd1);
    summary();
    $finish;
  end

  initial begin
    repeat (2) step();
    chk(sw_rdata_o == '0 && !beat_valid_o && !done_o, "R1 reset",
        {sw_rdata_o[31:0], beat_valid_o, done_o}, '0);
    rst_n = 1'b1;
    step();
    sw_write(32'h0000_1000, 1'b0);
    xfer(2'b10, 2'b00, 0, 0, 0, "R3 inc byte");
    xfer(2'b10, 2'b01, 0, 0, 0, "R6 inc word odd");
    xfer(2'b10, 2'b10, 0, 0, 0, "R6 inc long odd");
    xfer(2'b11, 2'b10, 0, 0, 0, "R7 dec long odd");
    xfer(2'b00, 2'b01, 0, 1, 0, "R5 fixed word stalled");
    sw_write(32'h0000_1002, 1'b0);
    xfer(2'b10, 2'b10, 0, 1, 0, "R6 inc long at 2");
    xfer(2'b11, 2'b01, 0, 0, 0, "R3 dec word");
    xfer(2'b11, 2'b00, 0, 0, 0, "R3 dec byte");
    offset_i = 32'hFFFF_FFF0;
    xfer(2'b01, 2'b00, 0, 0, 0, "R4 offset byte");
    xfer(2'b01, 2'b10, 0, 0, 0, "R4 offset long wraps 2^32");
    sw_write(32'h0000_DEAD, 1'b1);
    chk(sw_rdata_o == 32'h0000_0FE3, "R2 write ignored", {2'b0, sw_rdata_o}, 34'h0FE3);
    rpt_en_i = 1'b1;
    xfer(2'b10, 2'b10, 1, 0, 0, "R9 restore at block end");
    xfer(2'b10, 2'b01, 0, 0, 0, "R9 no block end");
    rpt_en_i = 1'b0;
    xfer(2'b10, 2'b00, 1, 0, 0, "R9 block end without enable");
    sw_write(32'h1234_567C, 1'b0);
    ext_en_i = 1'b1; ext_sz_i = 5'd4;
    xfer(2'b10, 2'b10, 0, 0, 0, "R10 wrap up");
    xfer(2'b11, 2'b00, 0, 0, 0, "R10 wrap down");
    ext_sz_i = 5'd0;
    xfer(2'b10, 2'b00, 0, 0, 0, "R10 size clamp");
    ext_en_i = 1'b0;
    xfer(2'b10, 2'b10, 0, 0, 1, "R11 start while busy");
    ack_i = 1'b1;
    step();
    ack_i = 1'b0;
    chk(sw_rdata_o == model_cur && !beat_valid_o, "R11 idle ack",
        {1'b0, beat_valid_o, sw_rdata_o}, {2'b0, model_cur});
    step();
    summary();
    $finish;
  end
endmodule